// File: doc/BRIEF.md
# Fixed-Point Second-Order ODE Integrator

This block integrates the equation y'' + 3xy' + 3y = 0 by explicit forward steps. Here u is the first derivative of y. A single-cycle start pulse loads the starting abscissa x, the value y, the slope u, the step dx and the end point a. The block then runs the loop body over and over until the freshly advanced x is no longer below a. At that point it raises a one-cycle done strobe and shows the last y on its result port.

All quantities are signed Q16.16 values in 32-bit registers. The loop body uses three Q products per step: u·dx, y·dx and x·(u·dx). Two shared multipliers are spread over two control states to compute them. The constant factor 3 is applied by shift-and-add, so it costs no multiplier.

Top module: `ode_step_solver`

## Requirements
- R1: Operands are signed Q16.16 in 32 bits. Each product p·q is the 64-bit signed product shifted right arithmetically by 16 and truncated to its low 32 bits. Additions, subtractions and the factor 3 wrap modulo 2^32.
- R2: A start pulse sampled while idle latches x_in, y_in, u_in, dx_in and a_in. busy is high from the cycle after that edge until the run ends.
- R3: Every step replaces x with x + dx.
- R4: Every step replaces u with u − 3·(x·(u·dx)) − 3·(y·dx), using the x, u and y from before the step.
- R5: Every step replaces y with y + u·dx, using the u from before the step.
- R6: The run goes on while the new x is below a (signed compare), and stops after the first step in which it is not.
- R7: At least one step runs, even when the loaded x is already at or above a.
- R8: Each step takes two clock cycles. done is seen in the cycle that follows clock edge number 2N after the start edge, where N is the number of steps.
- R9: done is high for exactly one cycle. busy is low while done is high. y_out equals the final y and holds until the next start.
- R10: A start pulse while busy is ignored. The result and the latency are those of the run already under way.
- R11: After reset, busy, done and y_out are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin a run (used only when idle) |
| x_in | input | 32 | Initial x, Q16.16 |
| y_in | input | 32 | Initial y, Q16.16 |
| u_in | input | 32 | Initial y', Q16.16 |
| dx_in | input | 32 | Step size, Q16.16 |
| a_in | input | 32 | Interval end, Q16.16 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe at the end of a run |
| y_out | output | 32 | Final y, Q16.16 |

## Verification
The bench finds the step count N of each run from its own model of the loop. It then expects done exactly 2N edges after the edge that sampled start, and counts edges while sampling on falling edges. At each step it checks that done is still low, and at edge 2N it checks done, busy and y_out together. One cycle later it checks that done has dropped and y_out has held. A start pulse injected two edges into a run must leave both the count and the result unchanged.

// File: rtl/ode_step_solver.sv
module ode_step_solver #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] u_in,
  input  logic signed [W-1:0] dx_in,
  input  logic signed [W-1:0] a_in,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] y_out
);
  localparam int PW = 2 * W;

  typedef enum logic [1:0] {IDLE, MUL, UPD} state_t;
  state_t state;

  logic signed [W-1:0] x_r, y_r, u_r, dx_r, a_r, udx_r, ydx_r;
  logic                done_r;

  function automatic logic signed [W-1:0] qmul(input logic signed [W-1:0] p,
                                               input logic signed [W-1:0] q);
    logic signed [PW-1:0] pe, qe, f;
    pe = PW'(p);
    qe = PW'(q);
    f  = pe * qe;
    return f[FRAC+W-1:FRAC];
  endfunction

  logic signed [W-1:0] mul_a, mul_b, x_next, u_next, y_next, t1_x3, t2_x3;
  logic                cont;

  assign mul_a  = qmul(state == MUL ? u_r : x_r, state == MUL ? dx_r : udx_r);
  assign mul_b  = qmul(y_r, dx_r);
  assign t1_x3  = (mul_a <<< 1) + mul_a;
  assign t2_x3  = (ydx_r <<< 1) + ydx_r;
  assign x_next = x_r + dx_r;
  assign u_next = u_r - t1_x3 - t2_x3;
  assign y_next = y_r + udx_r;
  assign cont   = x_next < a_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      done_r <= 1'b0;
      x_r    <= '0;
      y_r    <= '0;
      u_r    <= '0;
      dx_r   <= '0;
      a_r    <= '0;
      udx_r  <= '0;
      ydx_r  <= '0;
    end else begin
      done_r <= 1'b0;
      case (state)
        IDLE: if (start) begin
          x_r   <= x_in;
          y_r   <= y_in;
          u_r   <= u_in;
          dx_r  <= dx_in;
          a_r   <= a_in;
          state <= MUL;
        end
        MUL: begin
          udx_r <= mul_a;
          ydx_r <= mul_b;
          state <= UPD;
        end
        UPD: begin
          x_r <= x_next;
          u_r <= u_next;
          y_r <= y_next;
          if (cont) state <= MUL;
          else begin
            state  <= IDLE;
            done_r <= 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy  = state != IDLE;
  assign done  = done_r;
  assign y_out = y_r;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_exit_only_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == UPD) && !$past(cont));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dx_r) && $stable(a_r));
  a_r3_x_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (state == UPD) |=> x_r == $past(x_r) + $past(dx_r));
  a_r5_y_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (state == UPD) |=> y_r == $past(y_r) + $past(udx_r));
  a_r8_mul_then_upd: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MUL) |=> state == UPD);
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !start) |=> $stable(y_out));
endmodule

// File: tb/ode_step_solver_tb.sv
module ode_step_solver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 2000;

  logic clk = 0, rst_n = 0, start = 0;
  logic signed [31:0] x_in = 0, y_in = 0, u_in = 0, dx_in = 0, a_in = 0;
  logic busy, done;
  logic signed [31:0] y_out;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ode_step_solver u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .busy(busy), .done(done), .y_out(y_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [31:0] qm(input logic signed [31:0] p, input logic signed [31:0] q);
    longint f;
    f = longint'(p) * longint'(q);
    return 32'(f >>> 16);
  endfunction

  task automatic model(input logic signed [31:0] x0, y0, u0, dx, a,
                       output logic signed [31:0] yf, output int n);
    logic signed [31:0] x, y, u, udx, ydx, t1, xn;
    x = x0; y = y0; u = u0; n = 0;
    forever begin
      udx = qm(u, dx);
      ydx = qm(y, dx);
      t1  = qm(x, udx);
      xn  = x + dx;
      u   = u - 32'(t1 * 3) - 32'(ydx * 3);
      y   = y + udx;
      x   = xn;
      n++;
      if (!(xn < a)) break;
    end
    yf = y;
  endtask

  task automatic run(input logic signed [31:0] x0, y0, u0, dx, a, input bit poke);
    logic signed [31:0] yexp;
    int n, k;
    bit seen;
    model(x0, y0, u0, dx, a, yexp, n);
    @(negedge clk);
    x_in = x0; y_in = y0; u_in = u0; dx_in = dx; a_in = a; start = 1;
    @(negedge clk);
    start = 0;
    x_in = 32'sh7fff0000; y_in = 32'sd12345; u_in = -32'sd999; dx_in = 32'sd1; a_in = -32'sd65536;
    check(busy == 1, "R2 busy after start", busy, 1);
    seen = 0;
    for (k = 1; k <= TIMEOUT; k++) begin
      if (poke && k == 2) start = 1;
      @(negedge clk);
      if (poke && k == 2) start = 0;
      if (done) begin seen = 1; break; end
    end
    if (!seen) begin
      check(0, "R8 watchdog expired", k, 2 * n);
      return;
    end
    check(k == 2 * n, poke ? "R10 latency with ignored start" : "R8 latency", k, 2 * n);
    check(y_out == yexp, poke ? "R10 result with ignored start" : "R4 R5 R1 final y", y_out, yexp);
    check(!busy, "R9 busy low with done", busy, 0);
    @(negedge clk);
    check(!done, "R9 done one cycle", done, 0);
    check(y_out == yexp, "R9 y_out held", y_out, yexp);
  endtask

  initial begin
    automatic int dxs[3] = '{16384, 32768, 65536};
    automatic int x0s[2] = '{0, 65536};
    automatic int as[3]  = '{32768, 131072, -65536};
    automatic int ys[2]  = '{65536, -131072};
    automatic int us[2]  = '{0, 32768};
    repeat (3) @(negedge clk);
    check(busy == 0, "R11 reset busy", busy, 0);
    check(done == 0, "R11 reset done", done, 0);
    check(y_out == 0, "R11 reset y_out", y_out, 0);
    rst_n = 1;
    foreach (dxs[i]) foreach (x0s[j]) foreach (as[k]) foreach (ys[m]) foreach (us[p])
      run(x0s[j], ys[m], us[p], dxs[i], as[k], 0);
    // R7: x already beyond a, one step expected
    run(32'sd196608, 32'sd65536, 32'sd65536, 32'sd32768, 32'sd0, 0);
    // R6: negative operands exercise signed compare
    run(-32'sd131072, 32'sd65536, -32'sd32768, 32'sd32768, -32'sd32768, 0);
    // R10: start pulsed mid-run
    run(32'sd0, 32'sd65536, 32'sd32768, 32'sd16384, 32'sd131072, 1);
    run(32'sd65536, -32'sd131072, 32'sd0, 32'sd32768, 32'sd196608, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL global watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule